// File: doc/BRIEF.md
# Asynchronous SDR NAND Bus Sequencer

This block sits on the host side of a NAND flash device that uses the older asynchronous, single-data-rate bus. That bus has no clock. An 8-bit data path carries commands, addresses and data. Two latch-enable levels say what kind of byte is on it, and a separate write strobe or read strobe marks the transfer. The host hands the sequencer one bus cycle at a time through a valid/ready request port. A request names the cycle kind (command, address, data write or data read), the byte to send, and a flag. The flag asks the sequencer to wait for the device's ready/busy line before it takes the next request.

The sequencer builds each strobe from three phases: setup, strobe-low and hold. Each phase lasts a number of system clocks set by a configuration input. Written bytes are driven on the data output, with its output enable high, from the start of setup to the end of hold. On reads the bus is released, and the input byte is captured on the clock edge where the read strobe returns high. A one-clock turnaround with the chip deselected is placed between a read and a write in either order. The ready/busy input is asynchronous. It passes through a two-flop synchronizer and is polled only after a fixed minimum wait. The write-protect pin follows a host level.

The FSM states are IDLE, TURN, SETUP, PULSE, HOLD, BWAIT and POLL. Transitions:
- IDLE goes to TURN on an accepted request whose direction differs from the previous one, and to SETUP on any other accepted request.
- TURN goes to SETUP, SETUP goes to PULSE, and PULSE goes to HOLD, each when its phase count runs out. Leaving PULSE on a read captures the input byte.
- HOLD goes to BWAIT when the wait flag was set, and to IDLE otherwise.
- BWAIT goes to POLL after the minimum wait.
- POLL goes to IDLE once the synchronized ready/busy input reads high.

Top module: `nand_bus_seq`

## Requirements
- R1: While reset is held and right after it, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale and dq_oe are low, and req_ready is high.
- R2: req_op encodes the cycle kind. 0 is a command (nand_cle=1, nand_ale=0). 1 is an address (nand_ale=1, nand_cle=0). 2 is a data write and 3 is a data read (both latch enables low). These levels hold for the whole cycle, and nand_cle and nand_ale are never high together.
- R3: A write-type cycle (op 0, 1 or 2) keeps nand_ce_n low. It holds nand_we_n high for cfg_setup clocks, then low for cfg_pulse clocks, then high for cfg_hold clocks. dq_oe is high and dq_o equals req_data over all three phases.
- R4: A configuration count of zero gives a phase of one clock.
- R5: A read cycle keeps dq_oe low and pulses nand_re_n low for cfg_pulse clocks, with the same setup and hold framing. dq_i is captured into rd_data at the clock edge where nand_re_n rises. rd_valid is high for exactly one clock per read.
- R6: When a cycle's direction (read or write) differs from the previous cycle's, exactly one clock with nand_ce_n high and dq_oe low comes before its setup phase. When the direction is the same, there is no such clock. The write direction counts as the previous direction after reset.
- R7: After a cycle accepted with req_wait=1, req_ready stays low for MIN_WAIT clocks after hold, plus at least one polling clock, even when nand_rb is already high.
- R8: nand_rb is synchronized by two flops. Once polling has begun, req_ready rises on the third clock edge after nand_rb goes high.
- R9: A request held valid while the block is busy does not start any strobe or deselect activity. It is taken once req_ready is high.
- R10: nand_wp_n is always the inverse of wp_req.
- R11: nand_we_n and nand_re_n are never low together, and neither goes low while nand_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_op | input | 2 | Cycle kind: 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte to send on command, address or write cycles |
| req_wait | input | 1 | Wait for device ready after this cycle |
| req_ready | output | 1 | Sequencer can accept a request |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| rd_data | output | 8 | Last byte captured on a read cycle |
| cfg_setup | input | CNT_W (4) | Setup phase length in clocks |
| cfg_pulse | input | CNT_W (4) | Strobe-low phase length in clocks |
| cfg_hold | input | CNT_W (4) | Hold phase length in clocks |
| wp_req | input | 1 | Host request to write-protect the device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb | input | 1 | Device ready (1) / busy (0), asynchronous |
| dq_i | input | 8 | Data bus input from the pad |
| dq_o | output | 8 | Data bus output to the pad |
| dq_oe | output | 1 | Data bus output enable |

## Verification
The end of the minimum wait and the arrival of a synchronized ready can land on the same clock. In that case the first POLL clock already sees ready and must return to IDLE at once. The bench provokes this by leaving nand_rb high through a waited command and counting exactly MIN_WAIT+1 non-ready clocks. It also keeps a new request valid while the device is held busy, then releases nand_rb. The pending request must not touch the bus until the third edge after release, and must then run as a full, correctly timed cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } nand_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_BWAIT,
        ST_POLL
    } seq_state_e;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // a phase ends on its last counted clock; zero and one both give one clock
    assign done = (cnt_q <= TW'(1));
endmodule

// File: rtl/nand_rd_capture.sv
module nand_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic          valid,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                data <= bus_in;
            end
        end
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int TW          = 4,
    parameter int DW          = 8,
    parameter int MIN_WAIT    = 4,
    parameter int TURN_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [DW-1:0]    req_data,
    input  logic             req_wait,
    output logic             req_ready,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_pulse,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic             rb_ready,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             rd_capture,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe
);
    seq_state_e    state_q, state_d;
    nand_op_e      op_q;
    logic [DW-1:0] data_q;
    logic          wait_q;
    logic          last_rd_q;
    logic          accept;
    logic          new_is_rd;
    logic          cur_is_rd;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign new_is_rd = (nand_op_e'(req_op) == OP_RD);
    assign cur_is_rd = (op_q == OP_RD);

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_CMD;
            data_q    <= '0;
            wait_q    <= 1'b0;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q      <= nand_op_e'(req_op);
                data_q    <= req_data;
                wait_q    <= req_wait;
                last_rd_q <= new_is_rd;
            end
        end
    end

    // next state, timer loading and read capture
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rd_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (new_is_rd != last_rd_q) begin
                        state_d = ST_TURN;
                        tmr_val = TW'(TURN_CYCLES);
                    end else begin
                        state_d = ST_SETUP;
                        tmr_val = TW'(cfg_setup);
                    end
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_setup);
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_pulse);
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    state_d    = ST_HOLD;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(cfg_hold);
                    rd_capture = cur_is_rd;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    if (wait_q) begin
                        state_d  = ST_BWAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(MIN_WAIT);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BWAIT: begin
                if (tmr_done) begin
                    state_d = ST_POLL;
                end
            end
            ST_POLL: begin
                if (rb_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pin decode from the current state and latched request
    always_comb begin
        ce_n      = 1'b1;
        cle       = 1'b0;
        ale       = 1'b0;
        we_n      = 1'b1;
        re_n      = 1'b1;
        dq_o      = '0;
        dq_oe     = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_PULSE, ST_HOLD: begin
                ce_n  = 1'b0;
                cle   = (op_q == OP_CMD);
                ale   = (op_q == OP_ADDR);
                dq_oe = !cur_is_rd;
                dq_o  = cur_is_rd ? '0 : data_q;
                if (state_q == ST_PULSE) begin
                    we_n = cur_is_rd;
                    re_n = !cur_is_rd;
                end
            end
            ST_TURN, ST_BWAIT, ST_POLL: begin
                ce_n = 1'b1;
            end
            default: begin
                ce_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
    parameter int CNT_W       = 4,
    parameter int MIN_WAIT    = 4,
    parameter int TURN_CYCLES = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_data,
    input  logic             req_wait,
    output logic             req_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_pulse,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic             wp_req,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_wp_n,
    input  logic             nand_rb,
    input  logic [7:0]       dq_i,
    output logic [7:0]       dq_o,
    output logic             dq_oe
);
    localparam int DW     = 8;
    localparam int WAIT_W = $clog2(MIN_WAIT + 1);
    localparam int TURN_W = $clog2(TURN_CYCLES + 1);
    localparam int TW_A   = (CNT_W > WAIT_W) ? CNT_W : WAIT_W;
    localparam int TW     = (TW_A > TURN_W) ? TW_A : TURN_W;

    logic          rb_ready;
    logic          tmr_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          rd_capture;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) rb_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nand_rb),
        .sync_out (rb_ready)
    );

    nand_phase_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    nand_seq_fsm #(
        .CNT_W       (CNT_W),
        .TW          (TW),
        .DW          (DW),
        .MIN_WAIT    (MIN_WAIT),
        .TURN_CYCLES (TURN_CYCLES)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_data   (req_data),
        .req_wait   (req_wait),
        .req_ready  (req_ready),
        .cfg_setup  (cfg_setup),
        .cfg_pulse  (cfg_pulse),
        .cfg_hold   (cfg_hold),
        .rb_ready   (rb_ready),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .rd_capture (rd_capture),
        .ce_n       (nand_ce_n),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_o       (dq_o),
        .dq_oe      (dq_oe)
    );

    nand_rd_capture #(.DW(DW)) rd_cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .bus_in  (dq_i),
        .valid   (rd_valid),
        .data    (rd_data)
    );

    assign nand_wp_n = !wp_req;
endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       dq_oe,
    input logic [7:0] dq_o,
    input logic       rd_valid,
    input logic       req_ready,
    input logic       req_valid
);
    // R11
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !dq_oe);

    // R3
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(dq_o));

    // R3
    wr_hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (dq_oe && !nand_ce_n));

    // R5
    rd_valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!nand_re_n) && nand_re_n));

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nand_ce_n && nand_we_n && nand_re_n && !dq_oe));
endmodule

bind nand_bus_seq nand_bus_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .dq_oe     (dq_oe),
    .dq_o      (dq_o),
    .rd_valid  (rd_valid),
    .req_ready (req_ready),
    .req_valid (req_valid)
);

// File: tb/nand_bus_seq_tb_top.sv
module nand_bus_seq_tb_top;
    localparam int CNT_W    = 4;
    localparam int MIN_WAIT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'd0;
    logic [7:0]       req_data = 8'h00;
    logic             req_wait = 1'b0;
    logic             req_ready;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] cfg_setup = 4'd2;
    logic [CNT_W-1:0] cfg_pulse = 4'd3;
    logic [CNT_W-1:0] cfg_hold = 4'd1;
    logic             wp_req = 1'b0;
    logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic             nand_rb = 1'b1;
    logic [7:0]       dq_i;
    logic [7:0]       dq_o;
    logic             dq_oe;
    logic [7:0]       dev_byte = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #2 clk = !clk;

    // device model: drives the bus only while the read strobe is low
    assign dq_i = (!nand_re_n) ? dev_byte : 8'h00;

    nand_bus_seq #(.CNT_W(CNT_W), .MIN_WAIT(MIN_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_wait(req_wait), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold), .wp_req(wp_req),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_rb(nand_rb), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // present a request, wait until taken; returns at the first negedge after acceptance
    task automatic issue(input logic [1:0] op, input logic [7:0] data, input logic wt);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_data  = data;
        req_wait  = wt;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // measure one bus cycle's phases from the first clock after acceptance
    task automatic measure(input logic [1:0] op, input logic [7:0] data,
                           output int gap, output int s, output int p,
                           output int h, output int rdv, output int bad);
        logic is_rd;
        int   guard;
        is_rd = (op == 2'd3);
        gap = 0; s = 0; p = 0; h = 0; rdv = 0; bad = 0; guard = 0;
        while (nand_ce_n && guard < 50) begin
            if (dq_oe || !nand_we_n || !nand_re_n) bad++;
            gap++; guard++;
            @(negedge clk);
        end
        while (!nand_ce_n && (is_rd ? nand_re_n : nand_we_n) && guard < 100) begin
            s++; guard++;
            if (nand_cle != (op == 2'd0) || nand_ale != (op == 2'd1)) bad++;
            if (dq_oe != !is_rd || (!is_rd && dq_o != data)) bad++;
            if (is_rd ? !nand_we_n : !nand_re_n) bad++;
            if (rd_valid) rdv++;
            @(negedge clk);
        end
        while (!nand_ce_n && !(is_rd ? nand_re_n : nand_we_n) && guard < 150) begin
            p++; guard++;
            if (nand_cle != (op == 2'd0) || nand_ale != (op == 2'd1)) bad++;
            if (dq_oe != !is_rd || (!is_rd && dq_o != data)) bad++;
            if (rd_valid) rdv++;
            @(negedge clk);
        end
        while (!nand_ce_n && guard < 200) begin
            h++; guard++;
            if (nand_cle != (op == 2'd0) || nand_ale != (op == 2'd1)) bad++;
            if (dq_oe != !is_rd || (!is_rd && dq_o != data)) bad++;
            if (!nand_we_n || !nand_re_n) bad++;
            if (rd_valid) rdv++;
            @(negedge clk);
        end
        if (rd_valid) rdv++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ce_n", nand_ce_n, 1);
        check("R1 strobes", {nand_we_n, nand_re_n}, 3);
        check("R1 latch/oe", {nand_cle, nand_ale, dq_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_write(input logic [1:0] op, input logic [7:0] data,
                           input int es, input int ep, input int eh, input string tag);
        int gap, s, p, h, rdv, bad;
        issue(op, data, 1'b0);
        measure(op, data, gap, s, p, h, rdv, bad);
        check({tag, " no turnaround (R6)"}, gap, 0);
        check({tag, " setup clocks"}, s, es);
        check({tag, " pulse clocks"}, p, ep);
        check({tag, " hold clocks"}, h, eh);
        check({tag, " levels/data (R2)"}, bad, 0);
    endtask

    task automatic t_read(input logic [7:0] byte_v, input int egap, input string tag);
        int gap, s, p, h, rdv, bad;
        dev_byte = byte_v;
        issue(2'd3, 8'h00, 1'b0);
        measure(2'd3, 8'h00, gap, s, p, h, rdv, bad);
        check({tag, " R6 turnaround"}, gap, egap);
        check({tag, " R5 pulse clocks"}, p, int'(cfg_pulse));
        check({tag, " R5 released/levels"}, bad, 0);
        check({tag, " R5 rd_valid count"}, rdv, 1);
        check({tag, " R5 rd_data"}, rd_data, byte_v);
    endtask

    task automatic t_write_after_read();
        int gap, s, p, h, rdv, bad;
        issue(2'd2, 8'h3C, 1'b0);
        measure(2'd2, 8'h3C, gap, s, p, h, rdv, bad);
        check("R6 write after read turnaround", gap, 1);
        check("R3 write after read data", bad, 0);
    endtask

    task automatic t_min_wait();
        int gap, s, p, h, rdv, bad, nr;
        nand_rb = 1'b1;
        issue(2'd0, 8'h70, 1'b1);
        measure(2'd0, 8'h70, gap, s, p, h, rdv, bad);
        nr = 0;
        while (!req_ready && nr < 40) begin
            nr++;
            @(negedge clk);
        end
        check("R7 min wait with ready already high", nr, MIN_WAIT + 1);
    endtask

    task automatic t_busy_hold();
        int gap, s, p, h, rdv, bad, cnt, quiet;
        issue(2'd0, 8'h10, 1'b1);
        nand_rb = 1'b0;
        measure(2'd0, 8'h10, gap, s, p, h, rdv, bad);
        // queue the next request while the device is busy
        req_valid = 1'b1;
        req_op    = 2'd2;
        req_data  = 8'hA5;
        req_wait  = 1'b0;
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            if (req_ready || !nand_ce_n || !nand_we_n || dq_oe) quiet++;
            @(negedge clk);
        end
        check("R9 held off while busy", quiet, 0);
        nand_rb = 1'b1;
        cnt = 0;
        while (!req_ready && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        check("R8 ready latency after rb rise", cnt, 3);
        @(negedge clk);
        req_valid = 1'b0;
        measure(2'd2, 8'hA5, gap, s, p, h, rdv, bad);
        check("R9 queued write pulse", p, int'(cfg_pulse));
        check("R9 queued write data", bad, 0);
    endtask

    task automatic t_wp();
        wp_req = 1'b1;
        #1;
        check("R10 protect on", nand_wp_n, 0);
        wp_req = 1'b0;
        #1;
        check("R10 protect off", nand_wp_n, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                cfg_setup = 4'd2; cfg_pulse = 4'd3; cfg_hold = 4'd1;
                t_write(2'd0, 8'h80, 2, 3, 1, "R3 command");
                cfg_setup = 4'd1; cfg_pulse = 4'd1; cfg_hold = 4'd2;
                t_write(2'd1, 8'h5A, 1, 1, 2, "R3 address");
                cfg_setup = 4'd0; cfg_pulse = 4'd2; cfg_hold = 4'd0;
                t_write(2'd2, 8'hC3, 1, 2, 1, "R4 zero counts");
                cfg_setup = 4'd1; cfg_pulse = 4'd2; cfg_hold = 4'd1;
                t_read(8'h96, 1, "read after write");
                t_read(8'h69, 0, "read after read");
                t_write_after_read();
                t_min_wait();
                t_busy_hold();
                t_wp();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule